// File: doc/BRIEF.md
# UART Register Bank Decoder

This block is the host-facing register file of a 16550-class serial controller. A host addresses eight byte locations through a 3-bit address, separate read and write strobes, two active-low chip selects and byte-wide write and read buses. The block stores the control bytes and the scratch byte. It steers data-register accesses to the transmit and receive paths as single-cycle pulses, and it returns status bytes that the rest of the controller supplies.

Locations 0 and 1 are banked. Bit 7 of the line control byte chooses between the data/interrupt-enable pair and the two halves of the baud divisor. Several locations mean different things on a read and on a write: location 0 is the receive buffer on a read and the transmit holding byte on a write, and location 2 is interrupt identification on a read and FIFO control on a write. Serial shifting, FIFOs, baud generation and interrupt priority sit outside the block and appear only as ports. Data words shorter than eight bits are expected right-justified toward bit 0, which is the first bit on the line. This block passes bytes through unchanged.

Top module: `uart_regbank`

## Requirements
- R1: After a synchronous active-low reset, `divisor`, `line_ctrl`, `modem_ctrl`, `int_enable`, `fifo_ctrl`, the scratch byte, `rdata`, `tx_data`, `rx_pop` and `tx_push` are all zero.
- R2: An access takes place only when `cs0_n` or `cs1_n` is low. With both high, a strobe changes no stored byte, leaves `rdata` unchanged and produces no pulse.
- R3: With `line_ctrl[7]`=0, a read of location 0 returns `rx_data` on `rdata` and raises `rx_pop` for exactly the one clock after the sampled strobe.
- R4: With `line_ctrl[7]`=0, a write to location 0 raises `tx_push` for the one clock after the strobe, with `tx_data` equal to the written byte, and changes no stored byte.
- R5: With `line_ctrl[7]`=0, location 1 reads and writes `int_enable`.
- R6: With `line_ctrl[7]`=1, location 0 reads and writes `divisor[7:0]` and location 1 reads and writes `divisor[15:8]`. These accesses produce no `rx_pop` or `tx_push` and leave `int_enable` untouched.
- R7: Location 2 returns `int_ident` on a read and loads `fifo_ctrl` on a write, for either value of `line_ctrl[7]`. A read never returns the `fifo_ctrl` value.
- R8: Locations 3 to 7 are, for both bank settings, line control (read/write), modem control (read/write), `line_status` (read), `modem_status` (read) and scratch (read/write).
- R9: Writes to locations 5 and 6 change no output and no stored byte.
- R10: The bank-select bit is bit 7 of the line control byte, and a write to location 3 takes effect for the next access.
- R11: A write takes effect at the clock edge where the strobe is sampled and is visible on the outputs from then on. `rdata` is registered and holds the selected byte from the clock edge after the read strobe until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1_n | input | 1 | Second chip select, active low |
| addr | input | 3 | Register location |
| rd | input | 1 | Read strobe, one access per sampled cycle |
| wr | input | 1 | Write strobe, one access per sampled cycle |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered host read data |
| rx_data | input | DATA_W | Byte at the head of the receive path |
| line_status | input | DATA_W | Line status byte |
| modem_status | input | DATA_W | Modem status byte |
| int_ident | input | DATA_W | Interrupt identification byte |
| rx_pop | output | 1 | Receive byte consumed pulse |
| tx_push | output | 1 | Transmit byte offered pulse |
| tx_data | output | DATA_W | Byte offered with `tx_push` |
| divisor | output | 2*DATA_W | Baud divisor, high byte above low byte |
| line_ctrl | output | DATA_W | Line control byte |
| modem_ctrl | output | DATA_W | Modem control byte |
| int_enable | output | DATA_W | Interrupt enable byte |
| fifo_ctrl | output | DATA_W | FIFO control byte |

## Verification
The bench builds the block with its default `DATA_W` of 8, the width at which the location map and the bank-select bit position are defined. At that width, random bytes written to location 3 flip the bank bit often, so banked reads and writes interleave with line-control updates in the same run. Read and write strobes in the same cycle, chip selects that switch independently, and status inputs that change every cycle are also reached. Directed sequences cover the read/write asymmetry at locations 0 and 2 and the ignored writes to the status locations.

// File: rtl/uart_regbank_pkg.sv
// Shared constants for the serial controller register bank.
// Assumes a byte-wide host bus and eight locations.
package uart_regbank_pkg;
    // Location numbers; their order is what the host software decodes.
    localparam logic [2:0] LOC_DATA  = 3'd0;
    localparam logic [2:0] LOC_IEN   = 3'd1;
    localparam logic [2:0] LOC_IDFC  = 3'd2;
    localparam logic [2:0] LOC_LINE  = 3'd3;
    localparam logic [2:0] LOC_MODEM = 3'd4;
    localparam logic [2:0] LOC_LSTAT = 3'd5;
    localparam logic [2:0] LOC_MSTAT = 3'd6;
    localparam logic [2:0] LOC_SCR   = 3'd7;

    // Bit of the line control byte that selects the divisor bank.
    localparam int BANK_BIT = 7;

    // Index of each stored byte in the storage array.
    localparam int ST_DIVLO = 0;
    localparam int ST_DIVHI = 1;
    localparam int ST_IEN   = 2;
    localparam int ST_FIFO  = 3;
    localparam int ST_LINE  = 4;
    localparam int ST_MODEM = 5;
    localparam int ST_SCR   = 6;
    localparam int NSTORE   = 7;
endpackage

// File: rtl/uart_regbank_decode.sv
// Access decoder: turns host strobes, chip selects, address and bank bit
// into per-register write enables and data-path requests.
// Assumes strobes are sampled once per clock; purely combinational.
module uart_regbank_decode
    import uart_regbank_pkg::*;
(
    input  logic [2:0]        addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              bank,
    output logic [NSTORE-1:0] wen,
    output logic              rd_go,
    output logic              pop_req,
    output logic              push_req
);
    logic selected;
    logic wr_go;

    // Chip is selected when either active-low select is driven low.
    always_comb begin
        selected = !(cs0_n && cs1_n);
        wr_go    = wr && selected;
        rd_go    = rd && selected;
    end

    // Per-location write enables and data-path requests.
    always_comb begin
        wen            = '0;
        wen[ST_DIVLO]  = wr_go && (addr == LOC_DATA) && bank;
        wen[ST_DIVHI]  = wr_go && (addr == LOC_IEN)  && bank;
        wen[ST_IEN]    = wr_go && (addr == LOC_IEN)  && !bank;
        wen[ST_FIFO]   = wr_go && (addr == LOC_IDFC);
        wen[ST_LINE]   = wr_go && (addr == LOC_LINE);
        wen[ST_MODEM]  = wr_go && (addr == LOC_MODEM);
        wen[ST_SCR]    = wr_go && (addr == LOC_SCR);
        push_req       = wr_go && (addr == LOC_DATA) && !bank;
        pop_req        = rd_go && (addr == LOC_DATA) && !bank;
    end
endmodule

// File: rtl/uart_regbank_store.sv
// Storage for the host-writable bytes, one register per enable.
// Assumes at most one enable per cycle from the decoder.
module uart_regbank_store
    import uart_regbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NSTORE-1:0]              wen,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NSTORE-1:0][DATA_W-1:0]  q
);
    for (genvar i = 0; i < NSTORE; i++) begin : g_byte
        // Load this byte on its enable, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (wen[i])
                q[i] <= wdata;
        end
    end
endmodule

// File: rtl/uart_regbank_rdmux.sv
// Registered read multiplexer: selects the byte for a location and bank
// and holds it on the read bus until the next selected read.
// Assumes stored bytes and status inputs are stable at the sampling edge.
module uart_regbank_rdmux
    import uart_regbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_go,
    input  logic [2:0]                     addr,
    input  logic                           bank,
    input  logic [NSTORE-1:0][DATA_W-1:0]  q,
    input  logic [DATA_W-1:0]              rx_data,
    input  logic [DATA_W-1:0]              line_status,
    input  logic [DATA_W-1:0]              modem_status,
    input  logic [DATA_W-1:0]              int_ident,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] pick;

    // Choose the byte the host sees for this location and bank.
    always_comb begin
        unique case (addr)
            LOC_DATA:  pick = bank ? q[ST_DIVLO] : rx_data;
            LOC_IEN:   pick = bank ? q[ST_DIVHI] : q[ST_IEN];
            LOC_IDFC:  pick = int_ident;
            LOC_LINE:  pick = q[ST_LINE];
            LOC_MODEM: pick = q[ST_MODEM];
            LOC_LSTAT: pick = line_status;
            LOC_MSTAT: pick = modem_status;
            default:   pick = q[ST_SCR];
        endcase
    end

    // Capture the picked byte on a selected read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_go)
            rdata <= pick;
    end
endmodule

// File: rtl/uart_regbank.sv
// Host register bank of a 16550-class serial controller. Decodes banked
// locations, stores control bytes, registers the read bus and issues
// one-cycle pop/push pulses to the receive and transmit paths.
// Assumes a synchronous host bus sampled on the rising clock edge.
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs0_n,
    input  logic                  cs1_n,
    input  logic [2:0]            addr,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [DATA_W-1:0]     rx_data,
    input  logic [DATA_W-1:0]     line_status,
    input  logic [DATA_W-1:0]     modem_status,
    input  logic [DATA_W-1:0]     int_ident,
    output logic                  rx_pop,
    output logic                  tx_push,
    output logic [DATA_W-1:0]     tx_data,
    output logic [2*DATA_W-1:0]   divisor,
    output logic [DATA_W-1:0]     line_ctrl,
    output logic [DATA_W-1:0]     modem_ctrl,
    output logic [DATA_W-1:0]     int_enable,
    output logic [DATA_W-1:0]     fifo_ctrl
);
    logic [NSTORE-1:0]             wen;
    logic [NSTORE-1:0][DATA_W-1:0] q;
    logic                          rd_go;
    logic                          pop_req;
    logic                          push_req;
    logic                          bank;

    assign bank = q[ST_LINE][BANK_BIT];

    uart_regbank_decode u_decode (
        .addr     (addr),
        .rd       (rd),
        .wr       (wr),
        .cs0_n    (cs0_n),
        .cs1_n    (cs1_n),
        .bank     (bank),
        .wen      (wen),
        .rd_go    (rd_go),
        .pop_req  (pop_req),
        .push_req (push_req)
    );

    uart_regbank_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (wen),
        .wdata (wdata),
        .q     (q)
    );

    uart_regbank_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_go        (rd_go),
        .addr         (addr),
        .bank         (bank),
        .q            (q),
        .rx_data      (rx_data),
        .line_status  (line_status),
        .modem_status (modem_status),
        .int_ident    (int_ident),
        .rdata        (rdata)
    );

    // Register the data-path pulses and the byte offered for transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pop  <= 1'b0;
            tx_push <= 1'b0;
            tx_data <= '0;
        end else begin
            rx_pop  <= pop_req;
            tx_push <= push_req;
            if (push_req)
                tx_data <= wdata;
        end
    end

    // Present stored bytes on the control outputs.
    always_comb begin
        divisor    = {q[ST_DIVHI], q[ST_DIVLO]};
        line_ctrl  = q[ST_LINE];
        modem_ctrl = q[ST_MODEM];
        int_enable = q[ST_IEN];
        fifo_ctrl  = q[ST_FIFO];
    end
endmodule

// File: rtl/uart_regbank_chk.sv
// Property checker for the register bank, attached by bind.
// Observes ports only; assumes the synchronous active-low reset.
module uart_regbank_chk #(
    parameter int DATA_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs0_n,
    input logic                  cs1_n,
    input logic [2:0]            addr,
    input logic                  rd,
    input logic                  wr,
    input logic [DATA_W-1:0]     wdata,
    input logic [DATA_W-1:0]     rdata,
    input logic [DATA_W-1:0]     int_ident,
    input logic                  rx_pop,
    input logic                  tx_push,
    input logic [DATA_W-1:0]     tx_data,
    input logic [2*DATA_W-1:0]   divisor,
    input logic [DATA_W-1:0]     line_ctrl,
    input logic [DATA_W-1:0]     modem_ctrl,
    input logic [DATA_W-1:0]     int_enable,
    input logic [DATA_W-1:0]     fifo_ctrl
);
    logic sel;
    assign sel = !(cs0_n && cs1_n);

    // R2: no chip select, no change and no pulse
    assert_no_cs_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && cs1_n) |=> ($stable(divisor) && $stable(line_ctrl) && $stable(modem_ctrl)
            && $stable(int_enable) && $stable(fifo_ctrl) && $stable(rdata) && !rx_pop && !tx_push));

    // R3: a pop follows only a data-bank read of location 0
    assert_pop_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> ($past(rd) && $past(sel) && $past(addr) == 3'd0 && !$past(line_ctrl[7])));

    // R4: the pushed byte is the byte written with the strobe
    assert_push_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (tx_data == $past(wdata) && $past(wr) && $past(sel)));

    // R6: with the divisor bank selected, no data-path pulse follows
    assert_bank_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[7] |=> (!rx_pop && !tx_push));

    // R7: a read of location 2 returns interrupt identification
    assert_id_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel && addr == 3'd2) |=> (rdata == $past(int_ident)));

    // R9: writes to the status locations leave every control output alone
    assert_status_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && sel && (addr == 3'd5 || addr == 3'd6)) |=> ($stable(divisor)
            && $stable(line_ctrl) && $stable(modem_ctrl) && $stable(int_enable)
            && $stable(fifo_ctrl) && !tx_push));
endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs0_n        (cs0_n),
    .cs1_n        (cs1_n),
    .addr         (addr),
    .rd           (rd),
    .wr           (wr),
    .wdata        (wdata),
    .rdata        (rdata),
    .int_ident    (int_ident),
    .rx_pop       (rx_pop),
    .tx_push      (tx_push),
    .tx_data      (tx_data),
    .divisor      (divisor),
    .line_ctrl    (line_ctrl),
    .modem_ctrl   (modem_ctrl),
    .int_enable   (int_enable),
    .fifo_ctrl    (fifo_ctrl)
);

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
// Bench: directed sequences with literal expectations plus a random phase,
// all compared every clock against a behavioural reference model.
module tb_uart_regbank;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs0_n = 1'b1, cs1_n = 1'b1;
    logic [2:0]    addr = '0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [DW-1:0] wdata = '0, rx_data = '0, line_status = '0;
    logic [DW-1:0] modem_status = '0, int_ident = '0;
    logic [DW-1:0] rdata, tx_data, line_ctrl, modem_ctrl, int_enable, fifo_ctrl;
    logic [2*DW-1:0] divisor;
    logic          rx_pop, tx_push;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0, model_live = 0;

    always #2.5 clk = ~clk;

    uart_regbank #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .addr(addr),
        .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .rx_data(rx_data),
        .line_status(line_status), .modem_status(modem_status),
        .int_ident(int_ident), .rx_pop(rx_pop), .tx_push(tx_push),
        .tx_data(tx_data), .divisor(divisor), .line_ctrl(line_ctrl),
        .modem_ctrl(modem_ctrl), .int_enable(int_enable), .fifo_ctrl(fifo_ctrl)
    );

    // Reference model state: one integer per host-visible byte.
    int m_byte [8];   // 0 div lo, 1 div hi, 2 ien, 3 fifo, 4 line, 5 modem, 6 scratch
    int m_rdata, m_txd;
    bit m_pop, m_push;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Model update at each rising edge, reads use the old bytes first.
    always @(posedge clk) begin
        int a;
        bit s, bk;
        a = int'(addr);
        s = !(cs0_n && cs1_n);
        model_live = 1;
        if (!rst_n) begin
            foreach (m_byte[i]) m_byte[i] = 0;
            m_rdata = 0; m_txd = 0; m_pop = 0; m_push = 0;
        end else begin
            bk = m_byte[4][7];
            m_pop = 0; m_push = 0;
            if (rd && s) begin
                case (a)
                    0: begin m_rdata = bk ? m_byte[0] : int'(rx_data); m_pop = !bk; end
                    1: m_rdata = bk ? m_byte[1] : m_byte[2];
                    2: m_rdata = int'(int_ident);
                    3: m_rdata = m_byte[4];
                    4: m_rdata = m_byte[5];
                    5: m_rdata = int'(line_status);
                    6: m_rdata = int'(modem_status);
                    default: m_rdata = m_byte[6];
                endcase
            end
            if (wr && s) begin
                case (a)
                    0: if (bk) m_byte[0] = int'(wdata); else begin m_push = 1; m_txd = int'(wdata); end
                    1: m_byte[bk ? 1 : 2] = int'(wdata);
                    2: m_byte[3] = int'(wdata);
                    3: m_byte[4] = int'(wdata);
                    4: m_byte[5] = int'(wdata);
                    7: m_byte[6] = int'(wdata);
                    default: ;
                endcase
            end
        end
    end

    // Every-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (model_live && !done) begin
            check("R11 rdata", int'(rdata), m_rdata);
            check("R3 rx_pop", int'(rx_pop), int'(m_pop));
            check("R4 tx_push", int'(tx_push), int'(m_push));
            check("R4 tx_data", int'(tx_data), m_txd);
            check("R6 divisor", int'(divisor), (m_byte[1] << 8) | m_byte[0]);
            check("R5 int_enable", int'(int_enable), m_byte[2]);
            check("R7 fifo_ctrl", int'(fifo_ctrl), m_byte[3]);
            check("R10 line_ctrl", int'(line_ctrl), m_byte[4]);
            check("R8 modem_ctrl", int'(modem_ctrl), m_byte[5]);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            report();
        end
    end

    // One write access; returns the push pulse and byte seen one clock later.
    task automatic bus_wr(input logic [2:0] a, input logic [DW-1:0] d,
                          input logic c0, input logic c1,
                          output bit push, output int txd);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; cs0_n = c0; cs1_n = c1;
        @(negedge clk);
        wr = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1;
        push = tx_push; txd = int'(tx_data);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
        bit p; int t;
        bus_wr(a, d, 1'b0, 1'b1, p, t);
    endtask

    // One read access; returns the registered byte and the pop pulse.
    task automatic bus_rd(input logic [2:0] a, input logic c0, input logic c1,
                          output int d, output bit pop);
        @(negedge clk);
        addr = a; rd = 1'b1; cs0_n = c0; cs1_n = c1;
        @(negedge clk);
        rd = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1;
        d = int'(rdata); pop = rx_pop;
    endtask

    initial begin
        int d; bit p; int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", int'(rdata), 0);
        check("R1 divisor", int'(divisor), 0);
        check("R1 line/modem/ien/fifo", int'({line_ctrl, modem_ctrl, int_enable, fifo_ctrl}), 0);
        check("R1 pulses", int'({rx_pop, tx_push}), 0);
        bus_rd(3'd7, 1'b0, 1'b1, d, p);
        check("R1 scratch", d, 0);

        // R8 / R11: line control write visible right after its edge
        wr_reg(3'd3, 8'h03);
        check("R11 line_ctrl after edge", int'(line_ctrl), 8'h03);
        bus_rd(3'd3, 1'b1, 1'b0, d, p);
        check("R8 line read", d, 8'h03);

        // R4: data write pushes the byte
        bus_wr(3'd0, 8'h5A, 1'b0, 1'b0, p, t);
        check("R4 push", int'(p), 1);
        check("R4 push byte", t, 8'h5A);
        @(negedge clk);
        check("R4 push single cycle", int'(tx_push), 0);

        // R3: data read pops the receive byte
        rx_data = 8'hC3;
        bus_rd(3'd0, 1'b0, 1'b1, d, p);
        check("R3 rx byte", d, 8'hC3);
        check("R3 pop", int'(p), 1);
        @(negedge clk);
        check("R3 pop single cycle", int'(rx_pop), 0);

        // R5: interrupt enable
        wr_reg(3'd1, 8'h0F);
        bus_rd(3'd1, 1'b0, 1'b1, d, p);
        check("R5 ien read", d, 8'h0F);

        // R10 / R6: divisor bank
        wr_reg(3'd3, 8'h83);
        bus_wr(3'd0, 8'h34, 1'b0, 1'b1, p, t);
        check("R6 no push in divisor bank", int'(p), 0);
        wr_reg(3'd1, 8'h12);
        check("R6 divisor", int'(divisor), 16'h1234);
        check("R6 ien kept", int'(int_enable), 8'h0F);
        bus_rd(3'd1, 1'b0, 1'b1, d, p);
        check("R6 divisor hi read", d, 8'h12);
        bus_rd(3'd0, 1'b0, 1'b1, d, p);
        check("R6 divisor lo read", d, 8'h34);
        check("R6 no pop in divisor bank", int'(p), 0);

        // R7: location 2 in both banks
        int_ident = 8'hC1;
        wr_reg(3'd2, 8'hC7);
        check("R7 fifo_ctrl bank1", int'(fifo_ctrl), 8'hC7);
        bus_rd(3'd2, 1'b0, 1'b1, d, p);
        check("R7 id read bank1", d, 8'hC1);
        wr_reg(3'd3, 8'h03);
        check("R10 bank cleared", int'(line_ctrl), 8'h03);
        wr_reg(3'd2, 8'h01);
        bus_rd(3'd2, 1'b0, 1'b1, d, p);
        check("R7 id read bank0", d, 8'hC1);
        check("R7 fifo_ctrl bank0", int'(fifo_ctrl), 8'h01);

        // R8: status, modem control, scratch
        line_status = 8'h60; modem_status = 8'hB0;
        bus_rd(3'd5, 1'b0, 1'b1, d, p);
        check("R8 line status", d, 8'h60);
        bus_rd(3'd6, 1'b0, 1'b1, d, p);
        check("R8 modem status", d, 8'hB0);
        wr_reg(3'd4, 8'h1B);
        check("R8 modem_ctrl", int'(modem_ctrl), 8'h1B);
        wr_reg(3'd7, 8'hA5);
        bus_rd(3'd7, 1'b0, 1'b1, d, p);
        check("R8 scratch", d, 8'hA5);

        // R9: writes to the status locations ignored
        wr_reg(3'd5, 8'hFF);
        wr_reg(3'd6, 8'hFF);
        check("R9 controls kept", int'({line_ctrl, modem_ctrl, int_enable, fifo_ctrl}),
              32'h031B0F01);
        check("R9 divisor kept", int'(divisor), 16'h1234);
        bus_rd(3'd7, 1'b0, 1'b1, d, p);
        check("R9 scratch kept", d, 8'hA5);

        // R2: no chip select
        bus_wr(3'd3, 8'h80, 1'b1, 1'b1, p, t);
        check("R2 write ignored", int'(line_ctrl), 8'h03);
        bus_wr(3'd0, 8'h77, 1'b1, 1'b1, p, t);
        check("R2 no push", int'(p), 0);
        bus_rd(3'd5, 1'b1, 1'b1, d, p);
        check("R2 rdata held", d, 8'hA5);
        bus_rd(3'd0, 1'b1, 1'b1, d, p);
        check("R2 no pop", int'(p), 0);
        bus_wr(3'd4, 8'h02, 1'b1, 1'b0, p, t);
        check("R2 second select works", int'(modem_ctrl), 8'h02);

        // Random phase, checked by the every-clock model comparison.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            @(negedge clk);
            addr = r[2:0]; rd = r[3]; wr = r[4];
            cs0_n = r[5]; cs1_n = r[6] | r[7];
            wdata = r[15:8]; rx_data = r[23:16]; int_ident = r[31:24];
            line_status = r[23:16] ^ 8'h5C; modem_status = r[15:8] ^ 8'hA3;
            if (r[26:25] == 2'b00) rst_n = (r[30:27] != 4'd0);
            else rst_n = 1'b1;
        end
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        report();
    end
endmodule